// File: doc/BRIEF.md
# I2C Multi-Function Address Decoder

This block is the bus-facing front end of an I2C/SMBus target that answers on three 7-bit addresses at once. Each address consists of a fixed 4-bit function prefix in the upper bits, followed by the same three board-strapped bits. The block samples SCL and SDA with the system clock and finds START and STOP conditions. It shifts in the address byte and compares it against the three prefixes and the strap bits. On a match it acknowledges. It then reports which function was addressed, one-hot, together with the direction bit. The three functions are temperature sensing, plain memory read/write and the memory protection command.

After the address phase the block moves bytes in either direction, most significant bit first. Received bytes go out as a one-cycle strobe, and each one is acknowledged. For a read, the next byte to transmit is taken from an input port, and the master's acknowledge is reported. The block drives SDA only through an active-high pull-low enable, so the pad stays open-drain. The strap pins are captured again at every START, so a board may change them between accesses. The register file and the memory array behind the block are not part of it.

Top module: `i2cf_front`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state, and a rising SDA while SCL is high (STOP) returns the block to idle with SDA released.
- R2: The address byte is {prefix[3:0], strap-match[2:0], rw}, with rw in bit 0 (1 = read). Prefix 4'b0011 gives func_sel = 3'b001, prefix 4'b1010 gives 3'b010, and prefix 4'b0110 gives 3'b100. rnw copies bit 0.
- R3: Address bits [3:1] must equal the strap bits, and the prefix must be one of the three. Otherwise the block gives no acknowledge, keeps func_sel at zero, and leaves SDA undriven and rx_valid low until the next START or STOP.
- R4: The strap inputs are captured at each START. A change to them later in the same access has no effect on matching.
- R5: After a matching address, sda_oe is high during the ninth SCL pulse. It is released after the falling edge that ends that pulse (for a write), and it only ever changes while SCL is low.
- R6: In a write access, each byte is assembled MSB first and presented on rx_data with a one-cycle rx_valid. The slave then acknowledges the byte in the ninth pulse.
- R7: In a read access, tx_data is captured (tx_taken pulses) at the falling edge that ends each acknowledge pulse. It is driven MSB first, and SDA is released for the ninth pulse. There mst_ack_valid pulses with mst_ack = 1 for ACK (SDA low) and 0 for NACK. After a NACK the slave drives nothing until the next START or STOP.
- R8: func_sel and rnw become valid when the address acknowledge starts. They hold until STOP clears them or a repeated START replaces them with the new address's decode.
- R9: During and right after reset, sda_oe, func_sel, rnw, rx_valid, tx_taken and mst_ack_valid are all zero.
- R10: Bus timing comes only from SCL edges. SCL held low in the middle of a byte, for any length of time, does not disturb the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock as seen at the pad |
| sda_in | input | 1 | Bus data as seen at the pad |
| strap | input | 3 | Board strap bits matched against address bits [3:1] |
| tx_data | input | 8 | Next byte to send in a read access |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| func_sel | output | 3 | One-hot addressed function: bit0 temperature, bit1 memory, bit2 protection |
| rnw | output | 1 | Direction of the current access, 1 = read |
| rx_data | output | 8 | Last byte received from the master |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| tx_taken | output | 1 | One-cycle strobe when tx_data is captured |
| mst_ack_valid | output | 1 | One-cycle strobe when the master's acknowledge bit is sampled |
| mst_ack | output | 1 | Master acknowledge, 1 = ACK, 0 = NACK |

## Verification
A wrong internal state appears at the ports within one SCL phase. If the bit counter or the state is off, the acknowledge lands on the wrong pulse: the master sees no ACK in the ninth pulse, or a data bit pulled low, already in the first byte. A wrong decode or stale strap capture shows as a wrong or missing func_sel at the address acknowledge. A slave that does not drop out after a mismatch or a NACK shows as SDA pulled low during the following byte of clocks. A read path that shifts the wrong way returns a bit-reversed or shifted byte.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
    localparam int ADDR_W  = 7;
    localparam int STRAP_W = 3;
    localparam int PFX_W   = ADDR_W - STRAP_W;
    localparam int BYTE_W  = ADDR_W + 1;
    localparam int NFUNC   = 3;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    typedef logic [PFX_W-1:0]   pfx_t;
    typedef logic [NFUNC-1:0]   fsel_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [STRAP_W-1:0] strap_t;

    // index = one-hot position: temperature, memory, protection
    localparam pfx_t FUNC_PFX [NFUNC] = '{4'b0011, 4'b1010, 4'b0110};

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WRITE,
        ST_WR_ACK, ST_READ, ST_RD_ACK, ST_IGNORE
    } bus_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic pfx_t addr_prefix(input byte_t b);
        return b[BYTE_W-1 -: PFX_W];
    endfunction

    function automatic strap_t addr_strap(input byte_t b);
        return b[STRAP_W:1];
    endfunction
endpackage

// File: rtl/i2cf_sampler.sv
module i2cf_sampler
    import i2cf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
    logic scl_q, sda_q, scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/i2cf_addr_match.sv
module i2cf_addr_match
    import i2cf_pkg::*;
(
    input  byte_t  addr_byte,
    input  strap_t strap,
    output fsel_t  sel,
    output logic   hit,
    output logic   rnw
);
    fsel_t pfx_hit;

    for (genvar k = 0; k < NFUNC; k++) begin : g_pfx
        assign pfx_hit[k] = (addr_prefix(addr_byte) == FUNC_PFX[k]);
    end

    assign sel = (addr_strap(addr_byte) == strap) ? pfx_hit : '0;
    assign hit = |sel;
    assign rnw = addr_byte[0];
endmodule

// File: rtl/i2cf_front.sv
module i2cf_front
    import i2cf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  tx_data,
    output logic               sda_oe,
    output logic [NFUNC-1:0]   func_sel,
    output logic               rnw,
    output logic [BYTE_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               tx_taken,
    output logic               mst_ack_valid,
    output logic               mst_ack
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    bus_ev_t          ev;
    bus_state_t       state;
    byte_t            sh, shifted;
    logic [CNT_W-1:0] bitcnt;
    strap_t           strap_q;
    fsel_t            m_sel;
    logic             m_hit, m_rnw;

    i2cf_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    i2cf_addr_match u_match (
        .addr_byte(sh), .strap(strap_q), .sel(m_sel), .hit(m_hit), .rnw(m_rnw)
    );

    assign shifted = {sh[BYTE_W-2:0], ev.sda};

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            sh            <= '0;
            bitcnt        <= '0;
            strap_q       <= '0;
            sda_oe        <= 1'b0;
            func_sel      <= '0;
            rnw           <= 1'b0;
            rx_data       <= '0;
            rx_valid      <= 1'b0;
            tx_taken      <= 1'b0;
            mst_ack_valid <= 1'b0;
            mst_ack       <= 1'b0;
        end else begin
            rx_valid      <= 1'b0;
            tx_taken      <= 1'b0;
            mst_ack_valid <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                strap_q  <= strap;
                sda_oe   <= 1'b0;
                func_sel <= '0;
                rnw      <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                func_sel <= '0;
                rnw      <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WRITE: begin
                        if (ev.scl_rise && bitcnt != FULL) begin
                            sh     <= shifted;
                            bitcnt <= bitcnt + 1'b1;
                            if (state == ST_WRITE && bitcnt == LAST) begin
                                rx_data  <= shifted;
                                rx_valid <= 1'b1;
                            end
                        end else if (ev.scl_fall && bitcnt == FULL) begin
                            if (state == ST_WRITE) begin
                                sda_oe <= 1'b1;
                                state  <= ST_WR_ACK;
                            end else if (m_hit) begin
                                sda_oe   <= 1'b1;
                                func_sel <= m_sel;
                                rnw      <= m_rnw;
                                state    <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_WR_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR_ACK && rnw) begin
                                sh       <= tx_data;
                                sda_oe   <= ~tx_data[BYTE_W-1];
                                tx_taken <= 1'b1;
                                state    <= ST_READ;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WRITE;
                            end
                        end
                    end
                    ST_READ: begin
                        if (ev.scl_rise && bitcnt != FULL) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == FULL) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.scl_rise) begin
                            mst_ack       <= ~ev.sda;
                            mst_ack_valid <= 1'b1;
                        end else if (ev.scl_fall) begin
                            if (mst_ack) begin
                                sh       <= tx_data;
                                sda_oe   <= ~tx_data[BYTE_W-1];
                                tx_taken <= 1'b1;
                                bitcnt   <= '0;
                                state    <= ST_READ;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a START always reopens the address phase
    a_r1_start_enters_addr: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR));

    // R2: at most one function selected
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(func_sel));

    // R3: a rejected access never pulls SDA
    a_r3_ignore_no_drive: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R4: captured straps move only at a START
    a_r4_strap_held: assert property (@(posedge clk) disable iff (rst)
        !ev.start |=> $stable(strap_q));

    // R5: SDA drive changes only while the synchronized SCL is low
    a_r5_oe_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !ev.scl);

    // R6: received-byte strobes only in a selected write access
    a_r6_rx_in_write: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (func_sel != '0 && !rnw));

    // R8: STOP clears the selection
    a_r8_sel_cleared_by_stop: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (func_sel == '0));
endmodule

// File: tb/tb_i2cf_front.sv
module tb_i2cf_front;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b000;
    logic [7:0] tx_data = 8'hFF;
    logic       sda_oe, rnw, rx_valid, tx_taken, mst_ack_valid, mst_ack;
    logic [2:0] func_sel;
    logic [7:0] rx_data;
    logic       sda_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;
    logic       ack_last = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2cf_front dut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .strap(strap),
        .tx_data(tx_data), .sda_oe(sda_oe), .func_sel(func_sel), .rnw(rnw),
        .rx_data(rx_data), .rx_valid(rx_valid), .tx_taken(tx_taken),
        .mst_ack_valid(mst_ack_valid), .mst_ack(mst_ack)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
        if (mst_ack_valid) ack_last <= mst_ack;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // stimulus/expect: strap, address byte, ack, func_sel, rnw
    localparam logic [15:0] VEC [8] = '{
        {3'b000, 8'h30, 1'b1, 3'b001, 1'b0},
        {3'b101, 8'h3B, 1'b1, 3'b001, 1'b1},
        {3'b010, 8'hA4, 1'b1, 3'b010, 1'b0},
        {3'b111, 8'hAF, 1'b1, 3'b010, 1'b1},
        {3'b011, 8'h66, 1'b1, 3'b100, 1'b0},
        {3'b011, 8'h67, 1'b1, 3'b100, 1'b1},
        {3'b000, 8'h32, 1'b0, 3'b000, 1'b0},
        {3'b000, 8'h50, 1'b0, 3'b000, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, input int stall, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(Q);
            scl = 1'b0;
            if (i == 4) tick(stall);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q / 2);
        ack = ~sda_line;
        tick(Q / 2);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q / 2);
            b[i] = sda_line;
            tick(Q / 2);
            scl = 1'b0;
        end
        tick(2);
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1; tick(Q);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         rx_before;

        tick(5);
        chk("R9 sda_oe", 32'(sda_oe), 0);
        chk("R9 func_sel", 32'(func_sel), 0);
        chk("R9 strobes", 32'({rnw, rx_valid, tx_taken, mst_ack_valid}), 0);
        rst = 1'b0;
        tick(5);

        // R2 / R3 / R5 / R8 address table
        for (int v = 0; v < 8; v++) begin
            strap = VEC[v][15:13];
            bus_start();
            wr_byte(VEC[v][12:5], 0, ack);
            chk("R2/R3/R5 ack", 32'(ack), 32'(VEC[v][4]));
            chk("R2/R3 func_sel", 32'(func_sel), 32'(VEC[v][3:1]));
            chk("R2 rnw", 32'(rnw), 32'(VEC[v][0]));
            bus_stop();
            tick(4);
            chk("R1/R8 sel cleared by stop", 32'(func_sel), 0);
            chk("R1 sda released at stop", 32'(sda_oe), 0);
        end

        // R4: straps captured at START
        strap = 3'b101;
        bus_start();
        strap = 3'b000;
        wr_byte(8'h3A, 0, ack);
        chk("R4 ack with start-time strap", 32'(ack), 1);
        chk("R4 func_sel", 32'(func_sel), 32'h1);
        bus_stop();

        // R6 / R10 / R5: write with stalled clock
        strap = 3'b000;
        rx_before = rx_cnt;
        bus_start();
        wr_byte(8'h30, 0, ack);
        chk("R5 released after addr ack", 32'(sda_oe), 0);
        wr_byte(8'hA5, 3000, ack);
        chk("R6 data ack", 32'(ack), 1);
        chk("R6/R10 rx_data", 32'(rx_last), 32'hA5);
        wr_byte(8'h3C, 0, ack);
        chk("R6 second byte", 32'(rx_last), 32'h3C);
        chk("R6 rx count", 32'(rx_cnt - rx_before), 2);

        // R8 / R7: repeated start into a read
        tx_data = 8'h96;
        bus_start();
        wr_byte(8'hA1, 0, ack);
        chk("R8 resel ack", 32'(ack), 1);
        chk("R8 func_sel after repeated start", 32'(func_sel), 32'h2);
        chk("R8 rnw", 32'(rnw), 1);
        tx_data = 8'h5A;
        rd_byte(1'b1, rb);
        chk("R7 first read byte", 32'(rb), 32'h96);
        chk("R7 master ack", 32'(ack_last), 1);
        rd_byte(1'b0, rb);
        chk("R7 second read byte", 32'(rb), 32'h5A);
        chk("R7 master nack", 32'(ack_last), 0);
        tx_data = 8'h00;
        rd_byte(1'b0, rb);
        chk("R7 silent after nack", 32'(rb), 32'hFF);
        bus_stop();

        // R3: mismatch ignores following bytes
        rx_before = rx_cnt;
        bus_start();
        wr_byte(8'h32, 0, ack);
        chk("R3 no ack on mismatch", 32'(ack), 0);
        wr_byte(8'h00, 0, ack);
        chk("R3 data ignored", 32'(ack), 0);
        chk("R3 no rx strobe", 32'(rx_cnt - rx_before), 0);
        bus_stop();

        tick(10);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule